// File: doc/BRIEF.md
# Event-Flag Serial Port

This block is a single-byte asynchronous serial port that a processor drives through five 32-bit word registers. Software writes a byte to the data register to send one 8N1 frame on `tx_o`. A frame arriving on `rx_i` is latched into the data register, where it stays until software reads it. There is no queueing in either direction.

Completion is reported through two sticky event flags in the status register: one for a finished transmission and one for a received byte. Software clears each flag by writing a one to its bit. A single level interrupt line combines the two flags, each gated by its own enable bit in the control register. The receive side refuses new bytes while its event flag is still set, so an unread byte is never overwritten.

The bit time is 16 times the divisor in clock cycles. A divisor of zero is treated as one. The pass-through and break-enable bits are storage only.

Top module: `evt_uart`

## Requirements
- R1: After reset, status reads 0x1 (bit 0 = transmitter idle). Data, divisor, control and debug read 0, `irq_o` is low and `tx_o` is high.
- R2: Divisor (byte offset 0x4), control (0xC) and debug (0x10) store and read back all 32 written bits.
- R3: A write to the data register (offset 0x0) sends bits [7:0] on `tx_o` as one low start bit, eight data bits LSB first and one high stop bit. While the frame is in flight, status bit 0 reads 0.
- R4: Status bit 2 (transmit event) becomes 1 only when the stop bit has completed. It is still 0 in the middle of the stop bit.
- R5: A write to status (offset 0x8) clears bit 1 and/or bit 2 where the written value has a one. Bits written as zero, and bit 0, are not changed.
- R6: A valid received frame places its byte in the data register and sets status bit 1 (receive event). Data-register writes do not change the byte that is read back.
- R7: A frame that completes while status bit 1 is set is discarded. The data register keeps the earlier byte, including after the flag is later cleared.
- R8: A low pulse on `rx_i` that ends before the middle of the start bit is discarded. No event is raised and the data register is unchanged.
- R9: `irq_o` is high exactly when (status bit 1 AND control bit 0) OR (status bit 2 AND control bit 1).
- R10: A data-register write made while a frame is in flight is ignored. No second frame follows.
- R11: Reads of unmapped offsets (0x14 to 0x1C) or of non-word-aligned addresses return 0. Writes to them change no register.
- R12: Every serial bit lasts 16 × divisor clock cycles, counted on the low 16 bits of the divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as a read request |
| rx_i | input | 1 | Serial input, idle high |
| tx_o | output | 1 | Serial output, idle high |
| irq_o | output | 1 | Level interrupt |

## Verification
The transmitter is tested with bytes 0x5A and 0x96, whose alternating bit patterns show any bit-order or off-by-one-bit slip. It runs at divisors 1 and 2, which separates a correct bit time from a fixed one. The receiver gets a clean frame, a second frame while the first is still pending, and a short start glitch. These three cases tell latching apart from overwrite, and genuine start detection apart from edge triggering. The interrupt is checked with each enable alone against each flag alone, which exposes any swapped or merged gating.

// File: rtl/evt_uart_pkg.sv
package evt_uart_pkg;
  localparam int unsigned FRAME_BITS = 10;  // start + 8 data + stop
  localparam int unsigned OVERSAMPLE_LOG2 = 4;

  typedef enum logic [2:0] {
    REG_DATA = 3'd0,
    REG_DIV  = 3'd1,
    REG_STAT = 3'd2,
    REG_CTRL = 3'd3,
    REG_DBG  = 3'd4
  } reg_sel_e;

  localparam int unsigned ST_IDLE  = 0;
  localparam int unsigned ST_RXEVT = 1;
  localparam int unsigned ST_TXEVT = 2;
  localparam int unsigned CT_RXIE  = 0;
  localparam int unsigned CT_TXIE  = 1;
endpackage

// File: rtl/evt_uart_tx.sv
module evt_uart_tx
  import evt_uart_pkg::*;
#(
  parameter int unsigned BL_W = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [BL_W-1:0] bit_len_i,
  input  logic            start_i,
  input  logic [7:0]      data_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            tx_o
);
  localparam int unsigned IDX_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh_q;
  logic [IDX_W-1:0]      idx_q;
  logic [BL_W-1:0]       cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      sh_q   <= '1;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          sh_q   <= {1'b1, data_i, 1'b0};
          idx_q  <= '0;
          cnt_q  <= '0;
        end
      end else if (cnt_q == bit_len_i - 1'b1) begin
        cnt_q <= '0;
        if (idx_q == IDX_W'(FRAME_BITS - 1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          sh_q  <= {1'b1, sh_q[FRAME_BITS-1:1]};
          idx_q <= idx_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign tx_o = busy_o ? sh_q[0] : 1'b1;

  p_start_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !tx_o));
  p_done_ends_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: rtl/evt_uart_rx.sv
module evt_uart_rx #(
  parameter int unsigned BL_W = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [BL_W-1:0] bit_len_i,
  input  logic            rx_i,
  output logic            valid_o,
  output logic [7:0]      byte_o
);
  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_st_e;

  rx_st_e          st_q;
  logic            s1_q, s2_q;
  logic [BL_W-1:0] cnt_q;
  logic [2:0]      idx_q;
  logic [7:0]      sh_q;
  logic [BL_W-1:0] half_last, bit_last;

  assign half_last = (bit_len_i >> 1) - 1'b1;
  assign bit_last  = bit_len_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rx_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      valid_o <= 1'b0;
      byte_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      unique case (st_q)
        S_IDLE: if (!s2_q) begin
          st_q  <= S_START;
          cnt_q <= '0;
        end
        S_START: if (cnt_q == half_last) begin
          cnt_q <= '0;
          idx_q <= '0;
          st_q  <= s2_q ? S_IDLE : S_DATA;  // glitch: line back high at mid start
        end else cnt_q <= cnt_q + 1'b1;
        S_DATA: if (cnt_q == bit_last) begin
          cnt_q <= '0;
          sh_q  <= {s2_q, sh_q[7:1]};
          idx_q <= idx_q + 1'b1;
          if (idx_q == 3'd7) st_q <= S_STOP;
        end else cnt_q <= cnt_q + 1'b1;
        S_STOP: if (cnt_q == bit_last) begin
          cnt_q <= '0;
          st_q  <= S_IDLE;
          if (s2_q) begin
            valid_o <= 1'b1;
            byte_o  <= sh_q;
          end
        end else cnt_q <= cnt_q + 1'b1;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_valid_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/evt_uart.sv
module evt_uart
  import evt_uart_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [4:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        rx_i,
  output logic        tx_o,
  output logic        irq_o
);
  localparam int unsigned BL_W = DIV_W + OVERSAMPLE_LOG2;

  logic [31:0] div_q, ctrl_q, dbg_q;
  logic [7:0]  rx_byte_q;
  logic        rx_evt_q, tx_evt_q;
  logic        tx_busy, tx_done, rx_valid;
  logic [7:0]  rx_byte;
  logic        aligned, wr, rd;
  reg_sel_e    sel;
  logic        wr_data, wr_stat;
  logic [DIV_W-1:0] div_eff;
  logic [BL_W-1:0]  bit_len;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign sel     = reg_sel_e'(addr_i[4:2]);
  assign wr      = req_i && we_i && aligned;
  assign rd      = req_i && !we_i && aligned;
  assign wr_data = wr && (sel == REG_DATA);
  assign wr_stat = wr && (sel == REG_STAT);

  assign div_eff = (div_q[DIV_W-1:0] == '0) ? DIV_W'(1) : div_q[DIV_W-1:0];
  assign bit_len = {div_eff, {OVERSAMPLE_LOG2{1'b0}}};

  evt_uart_tx #(.BL_W(BL_W)) u_tx (
    .clk_i, .rst_ni,
    .bit_len_i(bit_len),
    .start_i  (wr_data),
    .data_i   (wdata_i[7:0]),
    .busy_o   (tx_busy),
    .done_o   (tx_done),
    .tx_o
  );

  evt_uart_rx #(.BL_W(BL_W)) u_rx (
    .clk_i, .rst_ni,
    .bit_len_i(bit_len),
    .rx_i,
    .valid_o  (rx_valid),
    .byte_o   (rx_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q     <= '0;
      ctrl_q    <= '0;
      dbg_q     <= '0;
      rx_byte_q <= '0;
      rx_evt_q  <= 1'b0;
      tx_evt_q  <= 1'b0;
    end else begin
      if (wr && sel == REG_DIV)  div_q  <= wdata_i;
      if (wr && sel == REG_CTRL) ctrl_q <= wdata_i;
      if (wr && sel == REG_DBG)  dbg_q  <= wdata_i;
      // set has priority over a same-cycle clear
      if (tx_done)                        tx_evt_q <= 1'b1;
      else if (wr_stat && wdata_i[ST_TXEVT]) tx_evt_q <= 1'b0;
      if (rx_valid && !rx_evt_q) begin
        rx_evt_q  <= 1'b1;
        rx_byte_q <= rx_byte;
      end else if (wr_stat && wdata_i[ST_RXEVT]) begin
        rx_evt_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (sel)
        REG_DATA: rdata_o = {24'd0, rx_byte_q};
        REG_DIV:  rdata_o = div_q;
        REG_STAT: rdata_o = {29'd0, tx_evt_q, rx_evt_q, !tx_busy};
        REG_CTRL: rdata_o = ctrl_q;
        REG_DBG:  rdata_o = dbg_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o = (rx_evt_q && ctrl_q[CT_RXIE]) || (tx_evt_q && ctrl_q[CT_TXIE]);

  p_tx_evt_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done |=> tx_evt_q);
  p_w1c_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i[ST_TXEVT] && !tx_done) |=> !tx_evt_q);
  p_rx_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_evt_q && !(wr_stat && wdata_i[ST_RXEVT])) |=> (rx_evt_q && $stable(rx_byte_q)));
endmodule

// File: tb/evt_uart_tb_top.sv
module evt_uart_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx = 1'b1;
  logic        tx, irq;
  int          checks = 0, fails = 0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_uart dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_i(rx), .tx_o(tx), .irq_o(irq)
  );

  task automatic chk(input string req_s, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req_s, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic rd_chk(input string req_s, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req_s, d, exp);
  endtask

  task automatic expect_tx(input string req_s, input logic [7:0] b, input int bl);
    logic [31:0] st;
    int wait_n = 0;
    while (tx !== 1'b0 && wait_n < 5000) begin
      @(negedge clk); wait_n++;
    end
    repeat (bl/2) @(negedge clk);
    chk({req_s, " start bit"}, {31'd0, tx}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      repeat (bl) @(negedge clk);
      chk({req_s, " data bit"}, {31'd0, tx}, {31'd0, b[i]});
    end
    repeat (bl) @(negedge clk);
    chk({req_s, " stop bit"}, {31'd0, tx}, 32'd1);
    rd(5'h08, st);
    chk("R4 tx event clear mid stop", {31'd0, st[2]}, 32'd0);
    repeat (bl/2 + 2) @(negedge clk);
    rd(5'h08, st);
    chk("R4 tx event after stop", {31'd0, st[2]}, 32'd1);
  endtask

  task automatic send_rx(input logic [7:0] b, input int bl);
    @(negedge clk);
    rx = 1'b0;
    repeat (bl) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (bl) @(negedge clk);
    end
    rx = 1'b1;
    repeat (bl + 4) @(negedge clk);
  endtask

  task automatic t_reset();
    rd_chk("R1 status", 5'h08, 32'h1);
    rd_chk("R1 data", 5'h00, 32'h0);
    rd_chk("R1 div", 5'h04, 32'h0);
    rd_chk("R1 ctrl", 5'h0C, 32'h0);
    rd_chk("R1 dbg", 5'h10, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 tx idle", {31'd0, tx}, 32'd1);
  endtask

  task automatic t_regs();
    wr(5'h04, 32'hA5A5_0001);
    wr(5'h0C, 32'h1234_5670);
    wr(5'h10, 32'hDEAD_BEEF);
    rd_chk("R2 div", 5'h04, 32'hA5A5_0001);
    rd_chk("R2 ctrl", 5'h0C, 32'h1234_5670);
    rd_chk("R2 dbg", 5'h10, 32'hDEAD_BEEF);
    wr(5'h0C, 32'h0);
    wr(5'h04, 32'h1);
  endtask

  task automatic t_tx_basic();
    logic [31:0] st;
    wr(5'h00, 32'hFFFF_FF5A);
    rd(5'h08, st);
    chk("R3 busy status", {31'd0, st[0]}, 32'd0);
    wr(5'h00, 32'h3C);  // ignored, frame in flight
    expect_tx("R3 frame 0x5A", 8'h5A, 16);
    begin
      int bad = 0;
      repeat (48) begin
        @(negedge clk);
        if (tx !== 1'b1) bad++;
      end
      chk("R10 no second frame", bad, 0);
    end
    rd(5'h08, st);
    chk("R10 one tx event idle", st, 32'h5);
  endtask

  task automatic t_w1c();
    wr(5'h08, 32'h2);
    rd_chk("R5 rx-only clear keeps tx evt", 5'h08, 32'h5);
    wr(5'h08, 32'hFFFF_FFFC);
    rd_chk("R5 tx clear leaves bit0", 5'h08, 32'h1);
  endtask

  task automatic t_rx();
    send_rx(8'hC3, 16);
    rd_chk("R6 rx event", 5'h08, 32'h3);
    rd_chk("R6 rx byte", 5'h00, 32'hC3);
    wr(5'h0C, 32'h1);
    chk("R9 rx irq enabled", {31'd0, irq}, 32'd1);
    wr(5'h0C, 32'h2);
    chk("R9 tx enable only", {31'd0, irq}, 32'd0);
    wr(5'h0C, 32'h0);
    send_rx(8'h81, 16);
    rd_chk("R7 byte kept while pending", 5'h00, 32'hC3);
    wr(5'h08, 32'h2);
    rd_chk("R7 flag cleared", 5'h08, 32'h1);
    rd_chk("R7 dropped byte not latched", 5'h00, 32'hC3);
  endtask

  task automatic t_glitch();
    @(negedge clk);
    rx = 1'b0;
    repeat (3) @(negedge clk);
    rx = 1'b1;
    repeat (40) @(negedge clk);
    rd_chk("R8 no event on glitch", 5'h08, 32'h1);
    rd_chk("R8 data unchanged", 5'h00, 32'hC3);
    send_rx(8'h7E, 16);
    rd_chk("R6 second byte", 5'h00, 32'h7E);
    wr(5'h08, 32'h2);
  endtask

  task automatic t_tx_div2();
    wr(5'h0C, 32'h2);
    wr(5'h04, 32'h2);
    wr(5'h00, 32'h96);
    expect_tx("R12 frame 0x96 div2", 8'h96, 32);
    chk("R9 tx irq", {31'd0, irq}, 32'd1);
    rd_chk("R6 data unaffected by tx write", 5'h00, 32'h7E);
    wr(5'h08, 32'h4);
    chk("R9 irq drops on clear", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_unmapped();
    rd_chk("R11 unmapped read", 5'h14, 32'h0);
    rd_chk("R11 misaligned read", 5'h05, 32'h0);
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h06, 32'h7777_7777);
    rd_chk("R11 div untouched", 5'h04, 32'h2);
    rd_chk("R11 ctrl untouched", 5'h0C, 32'h2);
    rd_chk("R11 dbg untouched", 5'h10, 32'hDEAD_BEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_tx_basic();
    t_w1c();
    t_rx();
    t_glitch();
    t_tx_div2();
    t_unmapped();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule